// File: doc/BRIEF.md
# Colour LCD Controller Register Slave

This block is the software-visible register slave of a colour LCD controller. It sits on a simple 32-bit single-cycle bus that addresses a 4 KB window by word address, and holds the panel timing words, two frame base addresses, the interrupt mask and raw status, the control word, a 128-entry raw palette RAM and a read-only identification window. From those registers it derives what the display pipeline needs: the active column count, the active row count, the pixel depth code and a display enable flag.

Interrupt sources live elsewhere. They report events through a one-cycle set-pulse vector. Software reads raw and masked status and clears bits through a write-one-to-clear location. A board strap selects a variant in which writes to the mask and control offsets trade places. Pixel fetch and timing generation are outside this block.

A request is presented for one cycle with `bus_sel` high. Writes take effect at that clock edge. Read data and the error flag appear in the following cycle.

Top module: `lcd_reg_slave`

## Requirements
- R1: After reset every register reads zero, `disp_cols` is 16, `disp_rows` is 1, `disp_depth` is 0 and `disp_en` is 0.
- R2: Word addresses 0 to 3 (timing 0 to 3), 4 (upper base) and 5 (lower base) are full 32-bit read/write registers. `bus_rdata` and `bus_err` are valid in the cycle after the request and stay valid for exactly that cycle.
- R3: `disp_cols` equals (timing0 bits 7:2 + 1) × 16, and `disp_rows` equals timing1 bits 9:0 + 1. No other timing bit affects either value.
- R4: The control word (word 7) drives the outputs: `disp_depth` is control bits 3:1, and `disp_en` is 1 only when control bit 0 and control bit 11 are both 1.
- R5: With `variant` low, a write to word 6 sets the interrupt mask and a write to word 7 sets control. With `variant` high these two write targets are swapped. Reads of word 6 always return the mask and reads of word 7 always return control.
- R6: A 1 on bit k of `irq_set` sets raw status bit k (word 8). Word 9 reads raw status AND mask. The mask and status are NIRQ bits wide and read with zeros above.
- R7: A write to word 10 clears each raw status bit whose written bit is 1. A set pulse in the same cycle wins over the clear. Word 10 reads zero without an error.
- R8: Word 11 returns the upper base and word 12 returns the lower base. Writes to words 8, 9, 11 and 12 are ignored and raise the error flag.
- R9: Word addresses 0x080 to 0x0FF (byte offsets 0x200 to 0x3FF) form a 128-word read/write palette, and the low 7 address bits give the entry index.
- R10: Word addresses 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFF) return one identification byte per word, in the order 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there are ignored and raise the error flag.
- R11: An access to any unmapped word address (13 to 0x07F, and 0x100 to 0x3F7) reads zero, leaves every register unchanged, and pulses `bus_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 1 | Board strap; swaps the mask and control write targets |
| bus_sel | input | 1 | Request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| bus_err | output | 1 | One-cycle pulse after an unmapped or wrong-direction access |
| irq_set | input | 4 | Per-bit set pulses from the interrupt sources |
| disp_cols | output | 11 | Active pixels per line |
| disp_rows | output | 11 | Active lines per frame |
| disp_depth | output | 3 | Pixel depth code |
| disp_en | output | 1 | Display enabled (enable and power both set) |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write to the same status bit in the same clock edge. The bench gets there by raising `irq_set` on the same falling edge that presents the clear write, so both are sampled by one rising edge. It then reads raw status to confirm that the set won for that bit and the clear took effect for the others. The strap swap is checked by toggling `variant` between write sequences and reading back both words 6 and 7. Every unmapped word address is written with all ones and then read back, and a timing register is reread afterwards to show that nothing changed.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;

    localparam int DATA_W  = 32;
    localparam int WADDR_W = 10;
    localparam int NIRQ    = 4;
    localparam int PAL_AW  = 7;
    localparam int ID_AW   = 3;
    localparam int DIM_W   = 11;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_PWR_BIT = 11;
    localparam int CTRL_DEP_LO  = 1;
    localparam int CTRL_DEP_HI  = 3;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_PAL  = 2'd2,
        TGT_ID   = 2'd3
    } tgt_e;

    typedef enum logic [3:0] {
        W_TIM0  = 4'd0,
        W_TIM1  = 4'd1,
        W_TIM2  = 4'd2,
        W_TIM3  = 4'd3,
        W_UPB   = 4'd4,
        W_LPB   = 4'd5,
        W_MASK  = 4'd6,
        W_CTRL  = 4'd7,
        W_RAW   = 4'd8,
        W_MST   = 4'd9,
        W_CLR   = 4'd10,
        W_UPC   = 4'd11,
        W_LPC   = 4'd12
    } word_e;

    typedef struct packed {
        tgt_e               tgt;
        logic [3:0]         word;
        logic [PAL_AW-1:0]  pal_idx;
        logic [ID_AW-1:0]   id_idx;
        logic               err;
    } dec_t;

    typedef struct packed {
        logic [DIM_W-1:0] cols;
        logic [DIM_W-1:0] rows;
        logic [2:0]       depth;
        logic             en;
    } disp_cfg_t;

    function automatic logic [7:0] id_byte(input logic [ID_AW-1:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

    function automatic logic [DIM_W-1:0] cols_of(input logic [5:0] ppl);
        cols_of = ({5'd0, ppl} + 11'd1) << 4;
    endfunction

    function automatic logic [DIM_W-1:0] rows_of(input logic [9:0] lpp);
        rows_of = {1'b0, lpp} + 11'd1;
    endfunction

endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
    import lcdr_pkg::*;
(
    input  logic [WADDR_W-1:0] waddr,
    input  logic               wr,
    input  logic               variant,
    output dec_t               dec
);
    logic [3:0] low_word;
    logic       is_ro_reg;

    assign low_word  = waddr[3:0];
    assign is_ro_reg = (low_word == W_RAW) || (low_word == W_MST) ||
                       (low_word == W_UPC) || (low_word == W_LPC);

    always_comb begin
        dec         = '0;
        dec.tgt     = TGT_NONE;
        dec.pal_idx = waddr[PAL_AW-1:0];
        dec.id_idx  = waddr[ID_AW-1:0];
        dec.word    = low_word;
        if (waddr[WADDR_W-1:4] == '0 && low_word <= 4'd12) begin
            dec.tgt = TGT_REG;
            if (wr && variant && low_word == W_MASK)
                dec.word = W_CTRL;
            else if (wr && variant && low_word == W_CTRL)
                dec.word = W_MASK;
            dec.err = wr && is_ro_reg;
        end else if (waddr[WADDR_W-1:PAL_AW] == 3'b001) begin
            dec.tgt = TGT_PAL;
        end else if (waddr[WADDR_W-1:ID_AW] == 7'h7F) begin
            dec.tgt = TGT_ID;
            dec.err = wr;
        end else begin
            dec.err = 1'b1;
        end
    end
endmodule

// File: rtl/lcdr_regfile.sv
module lcdr_regfile
    import lcdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [3:0]        word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [3:0]        rword,
    input  logic [NIRQ-1:0]   irq_set,
    output logic [DATA_W-1:0] rdata,
    output disp_cfg_t         cfg
);
    localparam int NTIM = 4;

    logic [DATA_W-1:0] tim_q [NTIM];
    logic [DATA_W-1:0] upb_q, lpb_q, ctrl_q;
    logic [NIRQ-1:0]   mask_q, raw_q, clr_bits;

    genvar gi;
    generate
        for (gi = 0; gi < NTIM; gi++) begin : g_tim
            always_ff @(posedge clk) begin
                if (rst)
                    tim_q[gi] <= '0;
                else if (we && word == 4'(gi))
                    tim_q[gi] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            upb_q  <= '0;
            lpb_q  <= '0;
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (we) begin
            case (word)
                W_UPB:   upb_q  <= wdata;
                W_LPB:   lpb_q  <= wdata;
                W_CTRL:  ctrl_q <= wdata;
                W_MASK:  mask_q <= wdata[NIRQ-1:0];
                default: ;
            endcase
        end
    end

    assign clr_bits = (we && word == W_CLR) ? wdata[NIRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~clr_bits) | irq_set;
    end

    always_comb begin
        case (rword)
            W_TIM0:  rdata = tim_q[0];
            W_TIM1:  rdata = tim_q[1];
            W_TIM2:  rdata = tim_q[2];
            W_TIM3:  rdata = tim_q[3];
            W_UPB:   rdata = upb_q;
            W_LPB:   rdata = lpb_q;
            W_MASK:  rdata = DATA_W'(mask_q);
            W_CTRL:  rdata = ctrl_q;
            W_RAW:   rdata = DATA_W'(raw_q);
            W_MST:   rdata = DATA_W'(raw_q & mask_q);
            W_UPC:   rdata = upb_q;
            W_LPC:   rdata = lpb_q;
            default: rdata = '0;
        endcase
    end

    assign cfg.cols  = cols_of(tim_q[0][7:2]);
    assign cfg.rows  = rows_of(tim_q[1][9:0]);
    assign cfg.depth = ctrl_q[CTRL_DEP_HI:CTRL_DEP_LO];
    assign cfg.en    = ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_PWR_BIT];

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (|irq_set) |=> ((raw_q & $past(irq_set)) == $past(irq_set)));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (we && word == W_CLR && irq_set == '0) |=> ((raw_q & $past(wdata[NIRQ-1:0])) == '0));

    p_enable_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg.en) |-> $past(we && word == W_CTRL));

    p_mask_cause_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask_q) |-> $past(we && word == W_MASK));
endmodule

// File: rtl/lcdr_palette.sv
module lcdr_palette
    import lcdr_pkg::*;
#(
    parameter int AW = PAL_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata    <= mem[idx];
    end
endmodule

// File: rtl/lcd_reg_slave.sv
module lcd_reg_slave
    import lcdr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               variant,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic [NIRQ-1:0]    irq_set,
    output logic [DIM_W-1:0]   disp_cols,
    output logic [DIM_W-1:0]   disp_rows,
    output logic [2:0]         disp_depth,
    output logic               disp_en
);
    dec_t              dec;
    disp_cfg_t         cfg;
    logic              acc_ok, wr_ok, rd_ok;
    logic [DATA_W-1:0] reg_rd, pal_rd;
    logic [DATA_W-1:0] reg_q;
    logic [7:0]        id_q;
    tgt_e              src_q;
    logic              err_q;

    lcdr_decode u_dec (
        .waddr   (bus_waddr),
        .wr      (bus_wr),
        .variant (variant),
        .dec     (dec)
    );

    assign acc_ok = bus_sel && !dec.err;
    assign wr_ok  = acc_ok && bus_wr;
    assign rd_ok  = acc_ok && !bus_wr;

    lcdr_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_ok && dec.tgt == TGT_REG),
        .word    (dec.word),
        .wdata   (bus_wdata),
        .rword   (dec.word),
        .irq_set (irq_set),
        .rdata   (reg_rd),
        .cfg     (cfg)
    );

    lcdr_palette u_pal (
        .clk   (clk),
        .we    (wr_ok && dec.tgt == TGT_PAL),
        .re    (rd_ok && dec.tgt == TGT_PAL),
        .idx   (dec.pal_idx),
        .wdata (bus_wdata),
        .rdata (pal_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            src_q <= TGT_NONE;
            reg_q <= '0;
            id_q  <= '0;
        end else begin
            err_q <= bus_sel && dec.err;
            src_q <= rd_ok ? dec.tgt : TGT_NONE;
            reg_q <= reg_rd;
            id_q  <= id_byte(dec.id_idx);
        end
    end

    always_comb begin
        case (src_q)
            TGT_REG: bus_rdata = reg_q;
            TGT_PAL: bus_rdata = pal_rd;
            TGT_ID:  bus_rdata = {24'd0, id_q};
            default: bus_rdata = '0;
        endcase
    end

    assign bus_err    = err_q;
    assign disp_cols  = cfg.cols;
    assign disp_rows  = cfg.rows;
    assign disp_depth = cfg.depth;
    assign disp_en    = cfg.en;

    p_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel));

    p_bad_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && dec.err) |=> (bus_rdata == '0 && bus_err));

    p_err_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !$past(bus_sel, 1) ) |-> 1'b0);
endmodule

// File: tb/lcd_reg_slave_test.sv
module lcd_reg_slave_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        variant;
    logic        bus_sel;
    logic        bus_wr;
    logic [9:0]  bus_waddr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq_set;
    logic [10:0] disp_cols, disp_rows;
    logic [2:0]  disp_depth;
    logic        disp_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lcd_reg_slave uut (
        .clk(clk), .rst(rst), .variant(variant),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .irq_set(irq_set), .disp_cols(disp_cols), .disp_rows(disp_rows),
        .disp_depth(disp_depth), .disp_en(disp_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        e = bus_err;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    function automatic logic [31:0] pal_pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ {7'(i), 25'h15A5A5A};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        logic [31:0] v;
        rst = 1'b1; variant = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_waddr = '0; bus_wdata = '0; irq_set = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(disp_cols == 11'd16, "R1 cols", 32'(disp_cols), 32'd16);
        chk(disp_rows == 11'd1,  "R1 rows", 32'(disp_rows), 32'd1);
        chk(disp_depth == 3'd0 && !disp_en, "R1 depth/en", {28'd0, disp_depth, disp_en}, 32'd0);
        for (int w = 0; w <= 12; w++) begin
            rd(10'(w), d, e);
            chk(d == 32'd0 && !e, "R1 reg zero", d, 32'd0);
        end

        // R2 plain registers, R8 current address readback
        for (int w = 0; w <= 5; w++) begin
            v = 32'hC0DE0000 ^ (32'(w) * 32'h01234567);
            wr(10'(w), v, e);
            chk(!e, "R2 write err", 32'(e), 32'd0);
        end
        for (int w = 0; w <= 5; w++) begin
            v = 32'hC0DE0000 ^ (32'(w) * 32'h01234567);
            rd(10'(w), d, e);
            chk(d == v, "R2 readback", d, v);
        end
        @(negedge clk);
        chk(!bus_err && bus_rdata == 32'd0, "R2 one-cycle", bus_rdata, 32'd0);
        rd(10'd11, d, e);
        chk(d == (32'hC0DE0000 ^ (32'd4 * 32'h01234567)), "R8 upper current", d, 32'hC0DE0000 ^ (32'd4 * 32'h01234567));
        rd(10'd12, d, e);
        chk(d == (32'hC0DE0000 ^ (32'd5 * 32'h01234567)), "R8 lower current", d, 32'hC0DE0000 ^ (32'd5 * 32'h01234567));
        for (int w = 8; w <= 12; w++) begin
            if (w == 10) continue;
            wr(10'(w), 32'hFFFF_FFFF, e);
            chk(e, "R8 ro write err", 32'(e), 32'd1);
        end
        rd(10'd11, d, e);
        chk(d == (32'hC0DE0000 ^ (32'd4 * 32'h01234567)), "R8 ro unchanged", d, 32'hC0DE0000 ^ (32'd4 * 32'h01234567));

        // R3 columns sweep
        for (int f = 0; f < 64; f++) begin
            v = (32'(f) << 2) | 32'hFFFF_FF03;
            wr(10'd0, v, e);
            chk(disp_cols == 11'((f + 1) * 16), "R3 cols", 32'(disp_cols), 32'((f + 1) * 16));
        end
        // R3 rows sweep
        for (int k = 0; k < 1024; k += 7) begin
            wr(10'd1, 32'hFFFF_FC00 | 32'(k), e);
            chk(disp_rows == 11'(k + 1), "R3 rows", 32'(disp_rows), 32'(k + 1));
        end
        wr(10'd1, 32'h0000_03FF, e);
        chk(disp_rows == 11'd1024, "R3 rows max", 32'(disp_rows), 32'd1024);

        // R4 control sweep: bit0 enable, bit11 power, bits 3:1 depth
        for (int c = 0; c < 64; c++) begin
            v = (32'(c[5]) << 11) | (32'(c[3:1]) << 1) | 32'(c[0]) | (32'(c[4]) << 9);
            wr(10'd7, v, e);
            chk(disp_depth == c[3:1], "R4 depth", 32'(disp_depth), 32'(c[3:1]));
            chk(disp_en == (c[0] & c[5]), "R4 enable", 32'(disp_en), 32'(c[0] & c[5]));
        end

        // R5 strap swap
        wr(10'd6, 32'h0000_0005, e);
        wr(10'd7, 32'h0000_0000, e);
        rd(10'd6, d, e);
        chk(d == 32'd5, "R5 mask normal", d, 32'd5);
        variant = 1'b1;
        wr(10'd6, 32'h0000_0801, e);
        chk(disp_en, "R5 swapped ctrl write", 32'(disp_en), 32'd1);
        wr(10'd7, 32'h0000_000A, e);
        rd(10'd6, d, e);
        chk(d == 32'd10, "R5 swapped mask read", d, 32'd10);
        rd(10'd7, d, e);
        chk(d == 32'h801, "R5 ctrl read", d, 32'h801);
        variant = 1'b0;
        wr(10'd7, 32'h0000_0000, e);
        chk(!disp_en, "R5 normal ctrl", 32'(disp_en), 32'd0);

        // R6 status set and masking sweep; R7 clear
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m += 5) begin
                wr(10'd10, 32'hF, e);
                wr(10'd6, 32'(m), e);
                @(negedge clk); irq_set = 4'(s);
                @(negedge clk); irq_set = '0;
                rd(10'd8, d, e);
                chk(d == 32'(s), "R6 raw", d, 32'(s));
                rd(10'd9, d, e);
                chk(d == 32'(s & m), "R6 masked", d, 32'(s & m));
            end
        end
        @(negedge clk); irq_set = 4'hF;
        @(negedge clk); irq_set = '0;
        wr(10'd10, 32'h0000_0005, e);
        rd(10'd8, d, e);
        chk(d == 32'hA, "R7 partial clear", d, 32'hA);
        rd(10'd10, d, e);
        chk(d == 32'd0 && !e, "R7 clear reads zero", d, 32'd0);
        // set and clear in the same cycle: set wins for that bit
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = 10'd10; bus_wdata = 32'hF; irq_set = 4'h2;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; irq_set = '0;
        rd(10'd8, d, e);
        chk(d == 32'h2, "R7 set beats clear", d, 32'h2);

        // R9 palette
        for (int i = 0; i < 128; i++) wr(10'h080 + 10'(i), pal_pat(i), e);
        for (int i = 0; i < 128; i++) begin
            rd(10'h080 + 10'(i), d, e);
            chk(d == pal_pat(i) && !e, "R9 palette", d, pal_pat(i));
        end

        // R10 identification
        for (int i = 0; i < 8; i++) begin
            rd(10'h3F8 + 10'(i), d, e);
            chk(d == {24'd0, exp_id(i)}, "R10 id", d, {24'd0, exp_id(i)});
            wr(10'h3F8 + 10'(i), 32'hFFFF_FFFF, e);
            chk(e, "R10 id write err", 32'(e), 32'd1);
        end

        // R11 unmapped sweep
        wr(10'd2, 32'h1357_9BDF, e);
        for (int a = 13; a < 1016; a++) begin
            if (a >= 128 && a < 256) continue;
            wr(10'(a), 32'hFFFF_FFFF, e);
            chk(e, "R11 write err", 32'(e), 32'd1);
            rd(10'(a), d, e);
            chk(d == 32'd0 && e, "R11 read zero", d, 32'd0);
        end
        rd(10'd2, d, e);
        chk(d == 32'h1357_9BDF, "R11 no side effect", d, 32'h1357_9BDF);
        @(negedge clk);
        chk(!bus_err, "R11 err one cycle", 32'(bus_err), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule